// File: doc/BRIEF.md
# Fully Associative Read Cache with Round-Robin Replacement

This block places a small, fully associative store of address-data pairs between a CPU read port and a main-memory read port. Every entry keeps the complete 15-bit word address next to its 12-bit data word, so any memory word can live in any entry. When a read arrives, its address is compared in parallel against all valid entries. A match answers from the store. A mismatch starts a fetch from main memory, hands the fetched word back to the CPU, and records the pair in the store.

Victims are picked by a single rotating pointer. After reset every entry is empty, and the pointer fills the entries in ascending index order. Once all of them hold data, each new pair overwrites the entry installed longest ago, so replacement is first-in-first-out. Two free-running counters report how many answers were hits and how many were misses, so a user can compute the hit ratio.

Top module: `fa_cache`

## Requirements
- R1: After reset, no entry is valid, both counters read zero, `reqReady` is 1, and `rspValid` and `memReq` are 0.
- R2: A read is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 for as long as a memory fetch is outstanding.
- R3: When the accepted address equals the stored address of a valid entry in all 15 bits, `rspValid` is 1 for one cycle on the next cycle, with `rspHit`=1 and the stored word on `rspData`. No memory fetch is made.
- R4: On a miss, `memReq` rises on the cycle after acceptance, with `memAddr` equal to the request address, and stays steady until `memAck`. `memData` is taken in the `memAck` cycle. On the following cycle the response shows that word with `rspHit`=0.
- R5: After a miss, the address-data pair is held in the store, so a later read of the same address hits and returns the fetched word.
- R6: Empty entries are filled in index order. Once all `ENTRIES` are valid, each new miss overwrites the pair that was installed earliest (FIFO).
- R7: The replacement pointer moves only when a pair is installed. Hits in any number do not change which pair is overwritten next.
- R8: An address that differs from a stored address in any single bit, including the most significant bit, is a miss.
- R9: `hitCount` rises by one with each hit response and `missCount` rises by one with each miss response. Neither changes in any other cycle.
- R10: Main-memory latency may be any number of cycles, one or more, and the answer does not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU read request present |
| reqAddr | input | ADDR_W (15) | CPU word address |
| reqReady | output | 1 | Cache can accept a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspData | output | DATA_W (12) | Returned data word |
| rspHit | output | 1 | 1 = served from the store, 0 = fetched |
| memReq | output | 1 | Fetch request to main memory |
| memAddr | output | ADDR_W (15) | Fetch address |
| memAck | input | 1 | Main memory answers in this cycle |
| memData | input | DATA_W (12) | Word from main memory, valid with memAck |
| hitCount | output | CNT_W (16) | Number of hit responses |
| missCount | output | CNT_W (16) | Number of miss responses |

## Verification
The hardest case to reach from the ports is a full store that must evict exactly the oldest pair while hits are mixed in between installs. A hit that wrongly moved the pointer, or a victim picked by any rule other than age, shows no effect until a later access. The bench uses four entries. It fills them, forces evictions, then places hits between misses and reads back the evicted and surviving addresses. A reference model computes the expected hit flag for every response. Addresses that differ only in the top bit or the lowest bit, together with memory latencies from one to four cycles, cover the full-width compare and the stall path.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ctrlState_t;

  typedef struct packed {
    logic accept;   // request taken this edge
    logic respHit;  // answer from the store
    logic install;  // memory word arrived: write entry, answer miss
  } ctrlStrb_t;

endpackage

// File: rtl/fa_cache_ctrl.sv
module fa_cache_ctrl
  import fa_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lookupHit,
  input  logic      memAck,
  output logic      reqReady,
  output logic      memReq,
  output ctrlStrb_t strb
);

  ctrlState_t state, stateNext;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    memReq        = (state == ST_FETCH);
    strb.accept   = reqReady && reqValid;
    strb.respHit  = strb.accept && lookupHit;
    strb.install  = memReq && memAck;
    stateNext     = state;
    if (strb.accept && !lookupHit) stateNext = ST_FETCH;
    else if (strb.install)         stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/fa_cache_dp.sv
module fa_cache_dp
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12,
  parameter int ENTRIES = 512,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              lookupHit,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspHit,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [ADDR_W-1:0]  entTag  [ENTRIES];
  logic [DATA_W-1:0]  entData [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [DATA_W-1:0]  hitData;
  logic [IDX_W-1:0]   fillPtr;
  logic [ADDR_W-1:0]  missAddr;

  // per-entry storage and comparator
  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    logic writeEn;
    assign writeEn     = strb.install && (fillPtr == IDX_W'(g));
    assign matchVec[g] = entValid[g] && (entTag[g] == reqAddr);

    always_ff @(posedge clk) begin
      if (!rstN)        entValid[g] <= 1'b0;
      else if (writeEn) entValid[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (writeEn) begin
        entTag[g]  <= missAddr;
        entData[g] <= memData;
      end
    end
  end

  // at most one entry matches: OR-combine the selected words
  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) hitData = hitData | entData[i];
  end
  assign lookupHit = |matchVec;
  assign memAddr   = missAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillPtr   <= '0;
      missAddr  <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
      rspHit    <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      rspValid <= strb.respHit || strb.install;
      rspHit   <= strb.respHit;
      if (strb.accept) missAddr <= reqAddr;
      if (strb.respHit) begin
        rspData  <= hitData;
        hitCount <= hitCount + CNT_W'(1);
      end
      if (strb.install) begin
        rspData   <= memData;
        missCount <= missCount + CNT_W'(1);
        fillPtr   <= (fillPtr == LAST_IDX) ? '0 : fillPtr + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/fa_cache.sv
module fa_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 12,
  parameter int ENTRIES = 512,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspHit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctrlStrb_t strb;
  logic      lookupHit;

  fa_cache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lookupHit (lookupHit),
    .memAck    (memAck),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .strb      (strb)
  );

  fa_cache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ENTRIES(ENTRIES),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .memData   (memData),
    .lookupHit (lookupHit),
    .memAddr   (memAddr),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .rspHit    (rspHit),
    .hitCount  (hitCount),
    .missCount (missCount)
  );

endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);

  a_r2_stall_on_fetch: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));

  a_r4_answer_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> rspValid && !rspHit);

  a_r3_hit_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> !memReq);

  a_r9_hit_count: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspHit |-> hitCount == $past(hitCount) + CNT_W'(1));

  a_r9_miss_count: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit |-> missCount == $past(missCount) + CNT_W'(1));

  a_r9_counts_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> $stable(hitCount) && $stable(missCount));

endmodule

bind fa_cache fa_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fa_cache_tb.sv
`timescale 1ns/1ps
module fa_cache_tb;

  localparam int ADDR_W  = 15;
  localparam int DATA_W  = 12;
  localparam int ENTRIES = 4;
  localparam int CNT_W   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqReady, rspValid, rspHit, memReq;
  logic [DATA_W-1:0] rspData;
  logic [ADDR_W-1:0] memAddr;
  logic              memAck = 1'b0;
  logic [DATA_W-1:0] memData = '0;
  logic [CNT_W-1:0]  hitCount, missCount;

  int total = 0;
  int bad = 0;
  int expHits = 0;
  int expMisses = 0;
  bit finished = 0;

  // scoreboard: {hit, data} plus the requirement tag
  logic [DATA_W:0] expQ[$];
  string           tagQ[$];

  // reference model of the store
  logic [ADDR_W-1:0] refTag [ENTRIES];
  bit                refValid [ENTRIES];
  int                refPtr = 0;

  always #2 clk = ~clk;

  fa_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .rspHit(rspHit), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .hitCount(hitCount), .missCount(missCount)
  );

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    int v;
    v = int'(a) * 13 + 7;
    return DATA_W'(v ^ (int'(a) >> 4) ^ (int'(a) >> 12));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issueRead(input logic [ADDR_W-1:0] a, input string tag);
    bit hit = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (refValid[i] && refTag[i] == a) hit = 1;
    if (hit) expHits++;
    else begin
      expMisses++;
      refTag[refPtr]   = a;
      refValid[refPtr] = 1;
      refPtr = (refPtr + 1) % ENTRIES;
    end
    expQ.push_back({hit, memWord(a)});
    tagQ.push_back(tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr  = a;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each response with the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) check(0, "R3 unexpected response", int'(rspData), 0);
        else begin
          logic [DATA_W:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(rspHit == e[DATA_W], {t, " hit flag"}, int'(rspHit), int'(e[DATA_W]));
          check(rspData == e[DATA_W-1:0], {t, " data"}, int'(rspData), int'(e[DATA_W-1:0]));
        end
      end
    end
  end

  // behavioural main memory, latency cycles 1..4 (R10)
  initial begin
    int lat = 1;
    forever begin
      @(negedge clk);
      if (memReq) begin
        check(!reqReady, "R2 ready low during fetch", int'(reqReady), 0);
        repeat (lat - 1) @(negedge clk);
        memData = memWord(memAddr);
        memAck  = 1'b1;
        @(negedge clk);
        memAck  = 1'b0;
        lat = (lat % 4) + 1;
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish();
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) refValid[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    check(!rspValid, "R1 rspValid", int'(rspValid), 0);
    check(!memReq, "R1 memReq", int'(memReq), 0);
    check(hitCount == 0, "R1 hitCount", int'(hitCount), 0);
    check(missCount == 0, "R1 missCount", int'(missCount), 0);

    issueRead(15'h0010, "R4 first miss");
    issueRead(15'h0010, "R3 R5 reread hits");
    issueRead(15'h4010, "R8 top bit differs");
    issueRead(15'h0011, "R8 low bit differs");
    issueRead(15'h7FFF, "R6 fill last entry");
    issueRead(15'h4010, "R3 hit in full store");
    issueRead(15'h0123, "R6 evict oldest");
    issueRead(15'h0010, "R6 evicted pair misses");
    issueRead(15'h0011, "R7 hit before install");
    issueRead(15'h7FFF, "R7 hit before install");
    issueRead(15'h0123, "R7 hit before install");
    issueRead(15'h0200, "R7 victim unchanged by hits");
    issueRead(15'h0011, "R7 replaced pair misses");
    issueRead(15'h0010, "R6 survivor hits");
    repeat (4) @(negedge clk);
    check(hitCount == CNT_W'(expHits), "R9 hitCount mid", int'(hitCount), expHits);
    check(missCount == CNT_W'(expMisses), "R9 missCount mid", int'(missCount), expMisses);

    // mixed pattern with varying latency
    for (int i = 0; i < 40; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(((i * 5) % 7) * 257 + 3);
      issueRead(a, "R10 mixed pattern");
    end
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R4 all responses seen", expQ.size(), 0);
    check(hitCount == CNT_W'(expHits), "R9 hitCount end", int'(hitCount), expHits);
    check(missCount == CNT_W'(expMisses), "R9 missCount end", int'(missCount), expMisses);
    finish();
  end

endmodule